// File: doc/BRIEF.md
# NAND Hamming ECC accumulator

This block sits beside a NAND flash data port and builds, byte by byte, the raw parity that a single-error-correcting Hamming code over a 256-byte block needs. Each time the data-port strobe is high, the byte on the port is folded into two accumulators. The first is a 16-bit line parity that is keyed to the byte's position in the block. The second is a 6-bit column parity that is keyed to the bit positions inside the byte. An 8-bit counter records how many bytes have passed, and it wraps at the block size. The byte's position in the block is the counter value before that byte is counted.

Software reaches the results through a small synchronous, byte-wide register interface. The interface has a single-cycle read strobe and a single-cycle write strobe, and writes carry no data. After a complete block the counter reads zero, so any other value shows that the block was partial. Software inverts the raw values and packs them into the three stored code bytes itself. It also clears the accumulators before each block by writing to the clear offset. Error location and correction are left to software.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset every accumulator and the counter are zero, and `reg_rdata` is 0x00.
- R2: Every cycle with `dp_stb` high and no clear adds one to the 8-bit byte counter. The counter wraps from 255 to 0, so it reads zero after exactly 256 bytes.
- R3: Let p be the XOR of all eight bits of an accepted byte and a be its position (the counter value before it is counted). For each k in 0..7, line parity bit 2k+1 toggles by p when a[k]=1, and bit 2k toggles by p when a[k]=0. A read at offset 0x00 returns bits 7..0 and a read at offset 0x04 returns bits 15..8.
- R4: For each j in 0..2, column parity bit 2j+1 accumulates the XOR of the data bits whose bit index has bit j set, and bit 2j accumulates the XOR of the data bits whose index has bit j clear. A read at offset 0x08 returns these six bits in bits 5..0, with bits 7..6 reading zero.
- R5: A read at offset 0x0C returns the byte counter.
- R6: A write to offset 0x10 sets both parity accumulators and the counter to zero on that clock edge.
- R7: When a clear and `dp_stb` fall in the same cycle, the clear wins and that byte is dropped. The next accepted byte takes position 0.
- R8: A write to any offset other than 0x10 changes no register.
- R9: A read at any offset other than 0x00, 0x04, 0x08 or 0x0C returns 0x00.
- R10: `reg_rdata` changes only on the edge that ends a read strobe. It shows the state from before that edge's update and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_addr | input | 5 | Register byte offset |
| dp_stb | input | 1 | Flash data-port access strobe, one byte per cycle |
| dp_byte | input | 8 | Byte moving through the data port |
| reg_rdata | output | 8 | Registered read data |

## Verification
The bench drives a single set bit through every bit index and through block positions chosen so that each address bit is set and clear. A line or column pair that was swapped, or keyed to the wrong bit, would show up as the wrong bit being set in the readback. The bench also streams a full block followed by a few extra bytes. This exposes a counter that saturates or misses the wrap, and line parity keyed to a position that was taken after the increment rather than before it. Clear and a data strobe are driven in the same cycle: a design that let the byte through would leave a nonzero count or parity. A read is also driven in the same cycle as a data strobe, together with writes and reads at offsets that are not mapped. These catch readback that shows post-update state, or offsets that decode too loosely.

// File: rtl/ecc_acc_pkg.sv
package ecc_acc_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] OFS_LP_LO = 5'h00;
    localparam logic [REG_AW-1:0] OFS_LP_HI = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CP    = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CNT   = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_CLR   = 5'h10;
endpackage

// File: rtl/ecc_byte_cnt.sv
module ecc_byte_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (stb) cnt <= cnt + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> $stable(cnt)); // R2
endmodule

// File: rtl/ecc_line_par.sv
module ecc_line_par #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int LP_W = 2 * AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            stb,
    input  logic [AW-1:0]   pos,
    input  logic [DW-1:0]   byte_in,
    output logic [LP_W-1:0] lp
);
    logic            bpar;
    logic [LP_W-1:0] toggle;

    assign bpar = ^byte_in;

    for (genvar k = 0; k < AW; k++) begin : g_pair
        assign toggle[2*k]   = bpar & ~pos[k];
        assign toggle[2*k+1] = bpar &  pos[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   lp <= '0;
        else if (clr) lp <= '0;
        else if (stb) lp <= lp ^ toggle;
    end

    AST_LP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr) |=> ($countones(lp ^ $past(lp)) == ((^$past(byte_in)) ? AW : 0))); // R3
    AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> $stable(lp)); // R3
endmodule

// File: rtl/ecc_col_par.sv
module ecc_col_par #(
    parameter int DW = 8,
    localparam int IW = $clog2(DW),
    localparam int CP_W = 2 * IW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            stb,
    input  logic [DW-1:0]   byte_in,
    output logic [CP_W-1:0] cp
);
    function automatic logic [DW-1:0] sel_mask(input int j);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = ((i >> j) & 1) != 0;
        return m;
    endfunction

    logic [CP_W-1:0] toggle;

    for (genvar j = 0; j < IW; j++) begin : g_pair
        localparam logic [DW-1:0] HI_M = sel_mask(j);
        assign toggle[2*j]   = ^(byte_in & ~HI_M);
        assign toggle[2*j+1] = ^(byte_in &  HI_M);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cp <= '0;
        else if (clr) cp <= '0;
        else if (stb) cp <= cp ^ toggle;
    end

    AST_CP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> $stable(cp)); // R4
endmodule

// File: rtl/ecc_reg_rd.sv
module ecc_reg_rd
    import ecc_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic [15:0]       lp_val,
    input  logic [7:0]        cp_val,
    input  logic [7:0]        cnt_val,
    output logic [7:0]        rdata
);
    logic [7:0] sel;

    always_comb begin
        case (addr)
            OFS_LP_LO: sel = lp_val[7:0];
            OFS_LP_HI: sel = lp_val[15:8];
            OFS_CP:    sel = cp_val;
            OFS_CNT:   sel = cnt_val;
            default:   sel = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   rdata <= 8'h00;
        else if (rd)  rdata <= sel;
    end

    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr != OFS_LP_LO && addr != OFS_LP_HI && addr != OFS_CP && addr != OFS_CNT)
        |=> (rdata == 8'h00)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R10
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import ecc_acc_pkg::*;
#(
    parameter int BLK_AW = 8,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              dp_stb,
    input  logic [DW-1:0]     dp_byte,
    output logic [7:0]        reg_rdata
);
    localparam int LP_W = 2 * BLK_AW;
    localparam int CP_W = 2 * $clog2(DW);

    logic              clr;
    logic [BLK_AW-1:0] cnt;
    logic [LP_W-1:0]   lp;
    logic [CP_W-1:0]   cp;

    assign clr = reg_wr && (reg_addr == OFS_CLR);

    ecc_byte_cnt #(.CNT_W(BLK_AW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stb(dp_stb), .cnt(cnt)
    );

    ecc_line_par #(.AW(BLK_AW), .DW(DW)) u_line (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stb(dp_stb),
        .pos(cnt), .byte_in(dp_byte), .lp(lp)
    );

    ecc_col_par #(.DW(DW)) u_col (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stb(dp_stb),
        .byte_in(dp_byte), .cp(cp)
    );

    ecc_reg_rd u_rd (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
        .lp_val(16'(lp)), .cp_val(8'(cp)), .cnt_val(8'(cnt)), .rdata(reg_rdata)
    );

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && lp == '0 && cp == '0)); // R6
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && dp_stb) |=> (cnt == '0)); // R7
    AST_PAR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp[1] ^ lp[0]) == (cp[1] ^ cp[0])) &&
        ((lp[LP_W-1] ^ lp[LP_W-2]) == (cp[CP_W-1] ^ cp[CP_W-2]))); // R3 R4
endmodule

// File: tb/tb_nand_ecc_acc.sv
`timescale 1ns/1ps
module tb_nand_ecc_acc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [4:0] reg_addr = 5'h0;
    logic       dp_stb = 1'b0;
    logic [7:0] dp_byte = 8'h0;
    logic [7:0] reg_rdata;

    always #2 clk = ~clk;

    nand_ecc_acc dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .dp_stb(dp_stb), .dp_byte(dp_byte),
        .reg_rdata(reg_rdata)
    );

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [7:0] hist[$];

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] a);
        reg_wr = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [4:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic feed(input logic [7:0] b);
        dp_stb = 1'b1; dp_byte = b;
        @(negedge clk);
        dp_stb = 1'b0;
        hist.push_back(b);
    endtask

    task automatic do_clear();
        do_wr(5'h10);
        hist.delete();
    endtask

    function automatic logic [15:0] exp_lp();
        logic [15:0] r = '0;
        for (int i = 0; i < hist.size(); i++) begin
            logic p = ^hist[i];
            logic [7:0] a = 8'(i);
            for (int k = 0; k < 8; k++)
                if (a[k]) r[2*k+1] ^= p; else r[2*k] ^= p;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_cp();
        logic [7:0] r = '0;
        for (int i = 0; i < hist.size(); i++)
            for (int b = 0; b < 8; b++)
                for (int j = 0; j < 3; j++)
                    if ((b >> j) & 1) r[2*j+1] ^= hist[i][b];
                    else r[2*j] ^= hist[i][b];
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] v;
        logic [15:0] el = exp_lp();
        do_rd(5'h00, v); chk({tag, " R3 lp_lo"}, v, el[7:0]);
        do_rd(5'h04, v); chk({tag, " R3 lp_hi"}, v, el[15:8]);
        do_rd(5'h08, v); chk({tag, " R4 cp"}, v, exp_cp());
        do_rd(5'h0C, v); chk({tag, " R5 cnt"}, v, 8'(hist.size() % 256));
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] lfsr;
        int pos[10] = '{0, 1, 2, 3, 7, 16, 85, 128, 170, 255};
        repeat (3) @(negedge clk);
        chk("R1 rdata after reset", reg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // hand value: one byte 0x01 at position 0
        feed(8'h01);
        do_rd(5'h00, v); chk("R3 single byte lp_lo", v, 8'h55);
        do_rd(5'h04, v); chk("R3 single byte lp_hi", v, 8'h55);
        do_rd(5'h08, v); chk("R4 single byte cp", v, 8'h15);

        // R6 clear
        do_clear();
        check_all("R6 after clear");

        // full block, byte = position, plus wrap
        for (int i = 0; i < 100; i++) feed(8'(i));
        do_rd(5'h0C, v); chk("R2 partial count", v, 8'd100);
        for (int i = 100; i < 256; i++) feed(8'(i));
        check_all("R2 full block");
        for (int i = 0; i < 5; i++) feed(8'(8'hA0 + i));
        check_all("R2 wrap plus five");

        // sweep of single set bits over positions
        for (int p = 0; p < 10; p++)
            for (int b = 0; b < 8; b++) begin
                do_clear();
                for (int z = 0; z < pos[p]; z++) feed(8'h00);
                feed(8'(1 << b));
                check_all($sformatf("R3 R4 sweep pos %0d bit %0d", pos[p], b));
            end

        // pseudo-random block
        do_clear();
        lfsr = 8'hE1;
        for (int i = 0; i < 256; i++) begin
            feed(lfsr);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        check_all("R2 R3 R4 random block");

        // R7 clear together with data strobe
        feed(8'h37);
        reg_wr = 1'b1; reg_addr = 5'h10; dp_stb = 1'b1; dp_byte = 8'hFF;
        @(negedge clk);
        reg_wr = 1'b0; dp_stb = 1'b0;
        hist.delete();
        check_all("R7 collision");
        feed(8'h01);
        check_all("R7 next byte at position 0");

        // R8 writes elsewhere have no effect
        feed(8'hC3); feed(8'h07);
        do_wr(5'h00); do_wr(5'h04); do_wr(5'h08); do_wr(5'h0C);
        do_wr(5'h14); do_wr(5'h03); do_wr(5'h11);
        check_all("R8 ignored writes");

        // R9 unmapped reads
        do_rd(5'h10, v); chk("R9 read 0x10", v, 8'h00);
        do_rd(5'h14, v); chk("R9 read 0x14", v, 8'h00);
        do_rd(5'h18, v); chk("R9 read 0x18", v, 8'h00);
        do_rd(5'h1C, v); chk("R9 read 0x1C", v, 8'h00);
        do_rd(5'h0D, v); chk("R9 read 0x0D", v, 8'h00);

        // R10 read in same cycle as data strobe shows pre-update state
        do_clear();
        feed(8'h11); feed(8'h22); feed(8'h33);
        reg_rd = 1'b1; reg_addr = 5'h0C; dp_stb = 1'b1; dp_byte = 8'h44;
        @(negedge clk);
        reg_rd = 1'b0; dp_stb = 1'b0;
        hist.push_back(8'h44);
        chk("R10 read with strobe", reg_rdata, 8'd3);
        feed(8'h55);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", reg_rdata, 8'd3);
        check_all("R10 after");

        done = 1'b1;
        report();
    end
endmodule